// File: doc/BRIEF.md
# Paired-Page Associative TLB Lookup

This block is a small, fully associative translation lookaside buffer. Each entry holds one virtual tag and two physical frames. The two frames serve an even/odd pair of adjacent virtual pages. A per-entry page mask widens the pair beyond the 4 KiB base page, so a single entry can cover 8 KiB, 32 KiB or larger regions.

A lookup presents a virtual address, the current 8-bit address-space identifier and a read/write flag, qualified by a strobe. The block compares the request against every entry in parallel. The lowest-numbered qualifying entry decides the outcome. Exactly one cycle after the strobe, the block registers four results:

- a result code,
- the translated physical address,
- a write-permission flag,
- a response-valid flag.

A separate write port loads an entry by index. Segment decoding, exception generation and refill handling are left to the surrounding logic.

Top module: `tlb_pair_lookup`

## Requirements
- R1: While reset is asserted and after it is released, `rsp_valid`, `rsp_code`, `rsp_pa` and `rsp_wperm` are all zero. Every stored entry is cleared to zero.
- R2: `rsp_valid` is high in the cycle after `lk_valid` was high at a clock edge, and low otherwise. The response fields change only at an edge where `lk_valid` is high; in all other cycles they hold their values.
- R3: An entry takes part in a lookup only if its global bit is 1, or its stored 8-bit identifier equals `lk_asid`.
- R4: The tag compare ignores address bits 12..0 and every bit set in the entry's mask field. All other bits of `lk_va` and of the stored tag must be equal. Mask bits below bit 13 have no effect.
- R5: The combined mask is the mask field OR 0x1FFF. The half is selected by the highest set bit of the combined mask: a 0 in that address bit selects the even half (frame 0), a 1 selects the odd half (frame 1). With a zero mask this is bit 12; with mask 0x6000 it is bit 14.
- R6: If the selected half's valid bit is 0, the code is 3 (INVALID), `rsp_pa` is 0 and `rsp_wperm` is 0.
- R7: A read to a valid half gives code 0 (MATCH). `rsp_pa` is that half's frame address OR the address bits set in (combined mask >> 1).
- R8: A write to a valid half whose dirty bit is 0 gives code 4 (DIRTY), with `rsp_pa` 0 and `rsp_wperm` 0.
- R9: On code 0, `rsp_wperm` equals the selected half's dirty bit. A write to a valid, dirty half is a code-0 hit with `rsp_wperm` 1.
- R10: If no entry qualifies, the code is 2 (NO-MATCH), `rsp_pa` is 0 and `rsp_wperm` is 0. Code 1 (bad address) is reserved and never produced.
- R11: When several entries qualify, the lowest index decides the result, even when its selected half is invalid.
- R12: A write through the entry port at a clock edge replaces all fields of entry `wr_idx`. Lookups strobed at later edges see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_vpn | input | 32 | Virtual tag (bits under the mask ignored) |
| wr_mask | input | 32 | Page mask; set bits widen the page pair |
| wr_global | input | 1 | Entry matches any identifier |
| wr_asid | input | 8 | Stored address-space identifier |
| wr_pfn0 | input | 32 | Even-half frame address |
| wr_v0 | input | 1 | Even-half valid |
| wr_d0 | input | 1 | Even-half dirty (writable) |
| wr_pfn1 | input | 32 | Odd-half frame address |
| wr_v1 | input | 1 | Odd-half valid |
| wr_d1 | input | 1 | Odd-half dirty (writable) |
| lk_valid | input | 1 | Lookup strobe |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_write | input | 1 | 1 for a store, 0 for a load |
| rsp_valid | output | 1 | Response registered from last cycle's strobe |
| rsp_code | output | 3 | 0 match, 2 no match, 3 invalid, 4 dirty |
| rsp_pa | output | 32 | Physical address on a match, else 0 |
| rsp_wperm | output | 1 | Write allowed on a match |

## Verification
The assertions assume that reset is applied before the first lookup. They also assume that `lk_write` is held for the whole strobed cycle, because the dirty-code and write-permission properties look back one cycle to it.

The assertions also assume that page masks are contiguous runs of ones starting at bit 13, so that the half-select bit is well defined. The stimulus only loads masks of that form. It drives every input at the falling edge, so each strobe and write is seen at exactly one rising edge.

// File: rtl/tlb_pkg.sv
// Shared widths, entry layout and result codes for the paired-page TLB.
// Assumes 4 KiB base pages, so the smallest even/odd pair spans 8 KiB.
package tlb_pkg;
    parameter int TLB_ADDR_W     = 32;
    parameter int TLB_ASID_W     = 8;
    parameter int TLB_PAGE_SHIFT = 12;

    typedef enum logic [2:0] {
        RC_MATCH   = 3'd0,
        RC_BADADDR = 3'd1,
        RC_NOMATCH = 3'd2,
        RC_INVALID = 3'd3,
        RC_DIRTY   = 3'd4
    } tlb_rc_e;

    typedef struct packed {
        logic [TLB_ADDR_W-1:0] vpn;
        logic [TLB_ADDR_W-1:0] mask;
        logic                  glob;
        logic [TLB_ASID_W-1:0] asid;
        logic [TLB_ADDR_W-1:0] pfn0;
        logic                  v0;
        logic                  d0;
        logic [TLB_ADDR_W-1:0] pfn1;
        logic                  v1;
        logic                  d1;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_entry_match.sv
// Compares one entry against a lookup request.
// Reports whether the entry qualifies (identifier and tag) and which half
// of the pair the address falls in. Assumes the mask field is a contiguous
// run of ones above the base pair offset.
module tlb_entry_match
    import tlb_pkg::*;
#(
    parameter int ADDR_W     = TLB_ADDR_W,
    parameter int ASID_W     = TLB_ASID_W,
    parameter int PAGE_SHIFT = TLB_PAGE_SHIFT
) (
    input  tlb_entry_t        ent,
    input  logic [ADDR_W-1:0] va,
    input  logic [ASID_W-1:0] asid,
    output logic              qual,
    output logic              odd
);
    localparam logic [ADDR_W-1:0] PAIR_OFS = ADDR_W'((64'd1 << (PAGE_SHIFT + 1)) - 64'd1);

    logic [ADDR_W-1:0] cmask;
    logic              id_ok;
    logic              tag_ok;

    // Combine the entry mask with the base pair offset, then test identifier, tag and half select.
    always_comb begin
        cmask  = ent.mask | PAIR_OFS;
        id_ok  = ent.glob || (ent.asid == asid);
        tag_ok = ((va & ~cmask) == (ent.vpn & ~cmask));
        qual   = id_ok && tag_ok;
        odd    = |(va & cmask & ~(cmask >> 1));
    end
endmodule

// File: rtl/tlb_first_hit.sv
// Priority picker: returns the lowest index whose request bit is set.
// Also reports whether any bit is set.
module tlb_first_hit #(
    parameter int N     = 16,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so that the lowest set index is written last and wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_access_check.sv
// Applies the valid and dirty checks to the chosen half and forms the
// result code, the physical address and the write permission.
// Assumes the entry, half select and hit flag all refer to the same lookup.
module tlb_access_check
    import tlb_pkg::*;
#(
    parameter int ADDR_W     = TLB_ADDR_W,
    parameter int PAGE_SHIFT = TLB_PAGE_SHIFT
) (
    input  logic              hit,
    input  tlb_entry_t        ent,
    input  logic              odd,
    input  logic [ADDR_W-1:0] va,
    input  logic              is_write,
    output tlb_rc_e           code,
    output logic [ADDR_W-1:0] pa,
    output logic              wperm
);
    localparam logic [ADDR_W-1:0] PAIR_OFS = ADDR_W'((64'd1 << (PAGE_SHIFT + 1)) - 64'd1);

    logic [ADDR_W-1:0] cmask;
    logic [ADDR_W-1:0] frame;
    logic              hv;
    logic              hd;

    // Pick the half, then decide among no-match, invalid, dirty and match.
    always_comb begin
        cmask = ent.mask | PAIR_OFS;
        frame = odd ? ent.pfn1 : ent.pfn0;
        hv    = odd ? ent.v1 : ent.v0;
        hd    = odd ? ent.d1 : ent.d0;
        code  = RC_NOMATCH;
        pa    = '0;
        wperm = 1'b0;
        if (hit) begin
            if (!hv) begin
                code = RC_INVALID;
            end else if (is_write && !hd) begin
                code = RC_DIRTY;
            end else begin
                code  = RC_MATCH;
                pa    = frame | (va & (cmask >> 1));
                wperm = hd;
            end
        end
    end
endmodule

// File: rtl/tlb_pair_lookup.sv
// Fully associative TLB with even/odd page pairs and per-entry page masks.
// Holds the entry storage and a write port. Runs a combinational lookup
// and registers the response one cycle after the lookup strobe.
// Assumes synchronous active-low reset and well-formed (contiguous) masks.
module tlb_pair_lookup
    import tlb_pkg::*;
#(
    parameter int ENTRIES    = 16,
    parameter int ADDR_W     = TLB_ADDR_W,
    parameter int ASID_W     = TLB_ASID_W,
    parameter int PAGE_SHIFT = TLB_PAGE_SHIFT,
    localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_vpn,
    input  logic [ADDR_W-1:0] wr_mask,
    input  logic              wr_global,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [ADDR_W-1:0] wr_pfn0,
    input  logic              wr_v0,
    input  logic              wr_d0,
    input  logic [ADDR_W-1:0] wr_pfn1,
    input  logic              wr_v1,
    input  logic              wr_d1,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    output logic              rsp_valid,
    output logic [2:0]        rsp_code,
    output logic [ADDR_W-1:0] rsp_pa,
    output logic              rsp_wperm
);
    tlb_entry_t        ents [ENTRIES];
    logic [ENTRIES-1:0] qual;
    logic [ENTRIES-1:0] odd;
    logic               any_hit;
    logic [IDX_W-1:0]   sel;
    tlb_entry_t         sel_ent;
    tlb_rc_e            nx_code;
    logic [ADDR_W-1:0]  nx_pa;
    logic               nx_wperm;

    // Entry storage: cleared on reset, one entry replaced per write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ents[i] <= '0;
        end else if (wr_en) begin
            ents[wr_idx] <= '{vpn: wr_vpn, mask: wr_mask, glob: wr_global, asid: wr_asid,
                              pfn0: wr_pfn0, v0: wr_v0, d0: wr_d0,
                              pfn1: wr_pfn1, v1: wr_v1, d1: wr_d1};
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        tlb_entry_match #(
            .ADDR_W(ADDR_W), .ASID_W(ASID_W), .PAGE_SHIFT(PAGE_SHIFT)
        ) u_cmp (
            .ent (ents[g]),
            .va  (lk_va),
            .asid(lk_asid),
            .qual(qual[g]),
            .odd (odd[g])
        );
    end

    tlb_first_hit #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
        .req(qual),
        .any(any_hit),
        .idx(sel)
    );

    // Route the winning entry's fields to the access checker.
    always_comb sel_ent = ents[sel];

    tlb_access_check #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_acc (
        .hit     (any_hit),
        .ent     (sel_ent),
        .odd     (odd[sel]),
        .va      (lk_va),
        .is_write(lk_write),
        .code    (nx_code),
        .pa      (nx_pa),
        .wperm   (nx_wperm)
    );

    // Response register: loads on a strobe, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= '0;
            rsp_pa    <= '0;
            rsp_wperm <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            if (lk_valid) begin
                rsp_code  <= nx_code;
                rsp_pa    <= nx_pa;
                rsp_wperm <= nx_wperm;
            end
        end
    end
endmodule

// File: rtl/tlb_pair_lookup_chk.sv
// Port-level checker for the paired-page TLB.
// Relates the registered response to the strobe and request of the cycle before.
module tlb_pair_lookup_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              lk_write,
    input logic              rsp_valid,
    input logic [2:0]        rsp_code,
    input logic [ADDR_W-1:0] rsp_pa,
    input logic              rsp_wperm
);
    // R2
    strobe_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    // R2
    idle_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> ($stable(rsp_pa) && $stable(rsp_code) && $stable(rsp_wperm)));
    // R10
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_code == 3'd0 || rsp_code == 3'd2 || rsp_code == 3'd3 || rsp_code == 3'd4));
    // R9
    wperm_only_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wperm |-> (rsp_code == 3'd0));
    // R8
    dirty_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 3'd4) |-> $past(lk_write));
    // R9
    write_hit_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 3'd0 && $past(lk_write)) |-> rsp_wperm);
    // R6
    miss_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != 3'd0) |-> (rsp_pa == '0));
endmodule

bind tlb_pair_lookup tlb_pair_lookup_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_pa(rsp_pa), .rsp_wperm(rsp_wperm)
);

// File: tb/sim_tlb_pair_lookup.sv
module sim_tlb_pair_lookup;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_vpn = '0, wr_mask = '0, wr_pfn0 = '0, wr_pfn1 = '0;
    logic        wr_global = 1'b0, wr_v0 = 1'b0, wr_d0 = 1'b0, wr_v1 = 1'b0, wr_d1 = 1'b0;
    logic [7:0]  wr_asid = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_write = 1'b0;
    logic        rsp_valid;
    logic [2:0]  rsp_code;
    logic [31:0] rsp_pa;
    logic        rsp_wperm;

    int checks = 0;
    int errors = 0;

    tlb_pair_lookup u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
        .wr_mask(wr_mask), .wr_global(wr_global), .wr_asid(wr_asid),
        .wr_pfn0(wr_pfn0), .wr_v0(wr_v0), .wr_d0(wr_d0),
        .wr_pfn1(wr_pfn1), .wr_v1(wr_v1), .wr_d1(wr_d1),
        .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid), .lk_write(lk_write),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_pa(rsp_pa), .rsp_wperm(rsp_wperm)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input int idx, input logic [31:0] vpn, input logic [31:0] mask,
                        input logic g, input logic [7:0] asid,
                        input logic [31:0] p0, input logic v0, input logic d0,
                        input logic [31:0] p1, input logic v1, input logic d1);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_vpn = vpn; wr_mask = mask; wr_global = g;
        wr_asid = asid; wr_pfn0 = p0; wr_v0 = v0; wr_d0 = d0; wr_pfn1 = p1; wr_v1 = v1; wr_d1 = d1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One strobed lookup; the response is registered at the next rising edge.
    task automatic lookup(input string req, input logic [31:0] va, input logic [7:0] asid,
                          input logic wr, input logic [2:0] ecode,
                          input logic [31:0] epa, input logic ewp);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = va; lk_asid = asid; lk_write = wr;
        @(negedge clk);
        lk_valid = 1'b0;
        check({req, " valid"}, 32'(rsp_valid), 32'd1);
        check({req, " code"}, 32'(rsp_code), 32'(ecode));
        check({req, " pa"}, rsp_pa, epa);
        check({req, " wperm"}, 32'(rsp_wperm), 32'(ewp));
    endtask

    task automatic t_reset();
        // R1
        check("R1 valid", 32'(rsp_valid), 32'd0);
        check("R1 code", 32'(rsp_code), 32'd0);
        check("R1 pa", rsp_pa, 32'd0);
        check("R1 wperm", 32'(rsp_wperm), 32'd0);
    endtask

    task automatic t_small_pair();
        load(0, 32'h0040_0000, 32'h0, 1'b0, 8'h11, 32'h1000_0000, 1'b1, 1'b1, 32'h2000_0000, 1'b1, 1'b0);
        lookup("R7 even read", 32'h0040_0123, 8'h11, 1'b0, 3'd0, 32'h1000_0123, 1'b1);
        lookup("R5 odd read", 32'h0040_1456, 8'h11, 1'b0, 3'd0, 32'h2000_0456, 1'b0);
        lookup("R8 odd write clean", 32'h0040_1456, 8'h11, 1'b1, 3'd4, 32'h0, 1'b0);
        lookup("R9 even write dirty", 32'h0040_0010, 8'h11, 1'b1, 3'd0, 32'h1000_0010, 1'b1);
        lookup("R3 asid mismatch", 32'h0040_0010, 8'h22, 1'b0, 3'd2, 32'h0, 1'b0);
        lookup("R10 tag miss", 32'h0040_2000, 8'h11, 1'b0, 3'd2, 32'h0, 1'b0);
    endtask

    task automatic t_big_pair();
        load(1, 32'h0080_0000, 32'h0000_6000, 1'b1, 8'h33, 32'h3000_0000, 1'b1, 1'b1, 32'h4000_0000, 1'b0, 1'b0);
        lookup("R4 R3 global even", 32'h0080_3ABC, 8'h55, 1'b0, 3'd0, 32'h3000_3ABC, 1'b1);
        lookup("R5 R6 odd invalid", 32'h0080_4000, 8'h55, 1'b0, 3'd3, 32'h0, 1'b0);
        lookup("R4 beyond mask", 32'h0080_8000, 8'h55, 1'b0, 3'd2, 32'h0, 1'b0);
    endtask

    task automatic t_priority();
        load(2, 32'h00C0_0000, 32'h0, 1'b1, 8'h00, 32'h5000_0000, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
        load(3, 32'h00C0_0000, 32'h0, 1'b1, 8'h00, 32'h6000_0000, 1'b1, 1'b1, 32'h0, 1'b0, 1'b0);
        lookup("R11 lower index invalid wins", 32'h00C0_0044, 8'h77, 1'b0, 3'd3, 32'h0, 1'b0);
        load(2, 32'h00C0_0000, 32'h0, 1'b1, 8'h00, 32'h5000_0000, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0);
        lookup("R12 R11 rewritten entry", 32'h00C0_0044, 8'h77, 1'b0, 3'd0, 32'h5000_0044, 1'b0);
    endtask

    task automatic t_hold();
        logic [31:0] pa_prev;
        lookup("R2 setup", 32'h0040_0200, 8'h11, 1'b0, 3'd0, 32'h1000_0200, 1'b1);
        pa_prev = rsp_pa;
        lk_va = 32'h0040_1000;
        lk_write = 1'b1;
        repeat (3) @(negedge clk);
        // R2: no strobe, so the response stays put and valid stays low
        check("R2 idle valid", 32'(rsp_valid), 32'd0);
        check("R2 idle pa", rsp_pa, pa_prev);
        check("R2 idle wperm", 32'(rsp_wperm), 32'd1);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_small_pair();
        t_big_pair();
        t_priority();
        t_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule